// File: doc/BRIEF.md
# Register Poll-Until-Match Engine

This block is an AXI4-Lite read manager that waits on a single register. A one-cycle start pulse hands it a word index, a bit-field position (offset and width) and an expected value. The engine reads the register, extracts the field and compares it with the low bits of the expected value. It finishes as soon as the field matches, or as soon as the subordinate answers with any response other than OKAY. Otherwise it stays quiet for a fixed number of clock cycles and reads the register again.

A retry budget limits the number of reads. When the budget is used up, the engine gives up and reports a timeout. The end of a poll is marked by a one-cycle done pulse. Alongside it the engine reports which of three outcomes occurred and the last response code it saw. These results stay visible until the next start.

The engine is meant to sit next to a control sequencer that must wait for a status bit or status field in a peripheral, without running software in the loop. Only one poll runs at a time. A start pulse that arrives during a poll is ignored.

Top module: `reg_poll_engine`

## Requirements
- R1: After reset, and whenever reset is applied during a poll, arvalid_o, rready_o, done_o, matched_o, error_o and timeout_o are low and resp_o is 00.
- R2: Every read uses byte address (BASE_WORD + index_i) × 4. arvalid_o and rready_o rise together on the cycle after start_i. arvalid_o and araddr_o hold until arready_i is seen, and arvalid_o is low on the cycle after that handshake.
- R3: rready_o stays high from the issue of a read until rvalid_i is seen, and it is low on the cycle after the read-data handshake.
- R4: A read with response 00 whose field rdata_i[ofs +: wid] equals expect_i[wid-1:0] ends the poll with matched_o = 1 and resp_o = 00.
- R5: A read whose response is non-zero ends the poll at once with error_o = 1 and resp_o set to that code (01 exclusive okay, 10 subordinate error, 11 decode error). This takes priority over a field match on the same read.
- R6: After an OKAY read with no match, exactly IDLE_GAP cycles pass with both arvalid_o and rready_o low before the next read is issued to the same address.
- R7: If RETRY_INIT reads in a row are OKAY and do not match, the poll ends after the last idle gap with timeout_o = 1 and resp_o = 00, and no further read is issued.
- R8: done_o is a one-cycle pulse. On done_o exactly one of matched_o, error_o and timeout_o is set. The status outputs hold until the next accepted start, which clears them. The bus is idle from done_o onward.
- R9: A start_i pulse while a poll is in progress is ignored. The running poll keeps its index, field and budget.
- R10: field_wid_i ranges from 0 to DATA_W. A width of DATA_W compares the whole word, and a width of 0 compares no bits, so the first OKAY read matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a poll |
| index_i | input | IDX_W | Word index added to BASE_WORD |
| field_ofs_i | input | OFS_W | Lowest bit of the compared field |
| field_wid_i | input | WID_W | Field width in bits, 0 to DATA_W |
| expect_i | input | DATA_W | Expected field value, right-aligned |
| done_o | output | 1 | One-cycle end-of-poll pulse |
| matched_o | output | 1 | Poll ended on a field match |
| error_o | output | 1 | Poll ended on a non-OKAY response |
| timeout_o | output | 1 | Poll ended with the retry budget used up |
| resp_o | output | 2 | Last response code received |
| araddr_o | output | ADDR_W | Read address |
| arvalid_o | output | 1 | Read address valid |
| arready_i | input | 1 | Read address ready |
| rdata_i | input | DATA_W | Read data |
| rresp_i | input | 2 | Read response |
| rvalid_i | input | 1 | Read data valid |
| rready_o | output | 1 | Read data ready |

## Verification
The bench builds the engine with RETRY_INIT = 3, IDLE_GAP = 4 and BASE_WORD = 0x100, in place of the defaults of 100000 and 501. With these values a full timeout, a match on the final retry and the exact idle-gap length can each be observed in a few dozen cycles. The bus model varies its address and data latencies from vector to vector. The vectors cover a field at bit 0, a field at the top bit, a full-word compare and a zero-width compare. They also cover every non-OKAY response code, including one that arrives together with a matching field.

// File: rtl/reg_poll_pkg.sv
`timescale 1ns/1ps
package reg_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_GAP  = 2'd2
  } poll_state_e;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } axi_resp_e;
endpackage

// File: rtl/poll_countdown.sv
`timescale 1ns/1ps
module poll_countdown #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // never step past the final count (R6, R7)
  assert_no_underflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i && !load_i |-> cnt_q > CNT_W'(1));
endmodule

// File: rtl/poll_field_cmp.sv
`timescale 1ns/1ps
module poll_field_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned OFS_W  = $clog2(DATA_W),
  parameter int unsigned WID_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WID_W-1:0]  wid_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic              hit_o
);
  logic [DATA_W-1:0] field_mask;
  logic [DATA_W-1:0] aligned;

  for (genvar b = 0; b < DATA_W; b++) begin : g_mask
    assign field_mask[b] = (wid_i > WID_W'(b));
  end

  assign aligned = word_i >> ofs_i;
  assign hit_o   = ((aligned ^ expect_i) & field_mask) == '0;
endmodule

// File: rtl/reg_poll_engine.sv
`timescale 1ns/1ps
module reg_poll_engine
  import reg_poll_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned IDX_W      = 12,
  parameter int unsigned BASE_WORD  = 0,
  parameter int unsigned RETRY_INIT = 100000,
  parameter int unsigned IDLE_GAP   = 501,
  parameter int unsigned OFS_W      = $clog2(DATA_W),
  parameter int unsigned WID_W      = $clog2(DATA_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  index_i,
  input  logic [OFS_W-1:0]  field_ofs_i,
  input  logic [WID_W-1:0]  field_wid_i,
  input  logic [DATA_W-1:0] expect_i,
  output logic              done_o,
  output logic              matched_o,
  output logic              error_o,
  output logic              timeout_o,
  output logic [1:0]        resp_o,
  output logic [ADDR_W-1:0] araddr_o,
  output logic              arvalid_o,
  input  logic              arready_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [1:0]        rresp_i,
  input  logic              rvalid_i,
  output logic              rready_o
);
  localparam int unsigned RETRY_W = $clog2(RETRY_INIT + 1);
  localparam int unsigned GAP_W   = $clog2(IDLE_GAP + 1);

  poll_state_e       state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WID_W-1:0]  wid_q;
  logic [DATA_W-1:0] exp_q;
  logic              arvalid_q, rready_q;
  logic              done_q, matched_q, error_q, timeout_q;
  logic [1:0]        resp_q;

  logic              start_go, ar_fire, r_fire, resp_ok, hit;
  logic              gap_last, gap_load, gap_dec, gap_end;
  logic              retry_last, retry_dec;
  logic [ADDR_W-1:0] word_addr;

  assign start_go = (state_q == ST_IDLE) && start_i;
  assign ar_fire  = arvalid_q && arready_i;
  assign r_fire   = (state_q == ST_READ) && rready_q && rvalid_i;
  assign resp_ok  = (rresp_i == RESP_OKAY);
  assign gap_load = r_fire && resp_ok && !hit;
  assign gap_end  = (state_q == ST_GAP) && gap_last;
  assign gap_dec  = (state_q == ST_GAP) && !gap_last;
  assign retry_dec = gap_end && !retry_last;

  poll_field_cmp #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W),
    .WID_W  (WID_W)
  ) u_cmp (
    .word_i   (rdata_i),
    .ofs_i    (ofs_q),
    .wid_i    (wid_q),
    .expect_i (exp_q),
    .hit_o    (hit)
  );

  poll_countdown #(.CNT_W(GAP_W)) u_gap_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (gap_load),
    .load_val_i (GAP_W'(IDLE_GAP)),
    .dec_i      (gap_dec),
    .last_o     (gap_last)
  );

  poll_countdown #(.CNT_W(RETRY_W)) u_retry_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_go),
    .load_val_i (RETRY_W'(RETRY_INIT)),
    .dec_i      (retry_dec),
    .last_o     (retry_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      ofs_q     <= '0;
      wid_q     <= '0;
      exp_q     <= '0;
      arvalid_q <= 1'b0;
      rready_q  <= 1'b0;
      done_q    <= 1'b0;
      matched_q <= 1'b0;
      error_q   <= 1'b0;
      timeout_q <= 1'b0;
      resp_q    <= RESP_OKAY;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            idx_q     <= index_i;
            ofs_q     <= field_ofs_i;
            wid_q     <= field_wid_i;
            exp_q     <= expect_i;
            matched_q <= 1'b0;
            error_q   <= 1'b0;
            timeout_q <= 1'b0;
            resp_q    <= RESP_OKAY;
            arvalid_q <= 1'b1;
            rready_q  <= 1'b1;
            state_q   <= ST_READ;
          end
        end
        ST_READ: begin
          if (ar_fire) arvalid_q <= 1'b0;
          if (r_fire) begin
            rready_q <= 1'b0;
            resp_q   <= rresp_i;
            if (!resp_ok) begin
              error_q <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (hit) begin
              matched_q <= 1'b1;
              done_q    <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gap_last) begin
            if (retry_last) begin
              timeout_q <= 1'b1;
              done_q    <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              arvalid_q <= 1'b1;
              rready_q  <= 1'b1;
              state_q   <= ST_READ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_addr = ADDR_W'(BASE_WORD) + ADDR_W'(idx_q);
  assign araddr_o  = word_addr << 2;
  assign arvalid_o = arvalid_q;
  assign rready_o  = rready_q;
  assign done_o    = done_q;
  assign matched_o = matched_q;
  assign error_o   = error_q;
  assign timeout_o = timeout_q;
  assign resp_o    = resp_q;

  assert_ar_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o && !arready_i |=> arvalid_o && $stable(araddr_o));
  assert_ar_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arvalid_o && arready_i |=> !arvalid_o);
  assert_r_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rready_o && rvalid_i |=> !rready_o);
  assert_err_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && error_o |-> resp_o != RESP_OKAY);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({matched_o, error_o, timeout_o}) == 1);
  assert_bus_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !arvalid_o && !rready_o);
  assert_wid_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> field_wid_i <= WID_W'(DATA_W));
endmodule

// File: tb/sim_reg_poll_engine.sv
`timescale 1ns/1ps
module sim_reg_poll_engine;
  localparam int unsigned RETRY = 3;
  localparam int unsigned GAP   = 4;
  localparam int unsigned BASE  = 32'h100;

  typedef struct packed {
    logic [11:0] idx;
    logic [4:0]  ofs;
    logic [5:0]  wid;
    logic [31:0] expv;
    logic [3:0]  match_at;  // read number that carries a match, 0 = none
    logic [3:0]  err_at;    // read number that carries a bad response, 0 = none
    logic [1:0]  code;
    logic [2:0]  kind;      // 1 matched, 2 error, 4 timeout
    logic [3:0]  reads;
    logic [1:0]  resp;
  } vec_t;

  // R10: vector 3 compares a full word, vector 7 a zero-width field
  localparam vec_t VECS [8] = '{
    '{12'h005,  5'd0, 6'd8,  32'h0000_00A5, 4'd1, 4'd0, 2'd0, 3'd1, 4'd1, 2'd0},
    '{12'h000, 5'd12, 6'd4,  32'h0000_0009, 4'd3, 4'd0, 2'd0, 3'd1, 4'd3, 2'd0},
    '{12'h007, 5'd31, 6'd1,  32'h0000_0001, 4'd2, 4'd0, 2'd0, 3'd1, 4'd2, 2'd0},
    '{12'h002,  5'd0, 6'd32, 32'hDEAD_BEEF, 4'd0, 4'd0, 2'd0, 3'd4, 4'd3, 2'd0},
    '{12'h003,  5'd4, 6'd8,  32'h0000_003C, 4'd0, 4'd2, 2'd2, 3'd2, 4'd2, 2'd2},
    '{12'h009,  5'd8, 6'd16, 32'h0000_1234, 4'd1, 4'd1, 2'd3, 3'd2, 4'd1, 2'd3},
    '{12'h001, 5'd16, 6'd3,  32'h0000_0005, 4'd0, 4'd1, 2'd1, 3'd2, 4'd1, 2'd1},
    '{12'hEFF,  5'd2, 6'd0,  32'h0000_0007, 4'd1, 4'd0, 2'd0, 3'd1, 4'd1, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] index = '0;
  logic [4:0]  ofs = '0;
  logic [5:0]  wid = '0;
  logic [31:0] expv = '0;
  logic done_o, matched_o, error_o, timeout_o, arvalid_o, rready_o;
  logic [1:0]  resp_o;
  logic [31:0] araddr_o;
  logic arready = 1'b0, rvalid = 1'b0;
  logic [31:0] rdata = '0;
  logic [1:0]  rresp = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  reg_poll_engine #(
    .ADDR_W(32), .DATA_W(32), .IDX_W(12), .BASE_WORD(BASE),
    .RETRY_INIT(RETRY), .IDLE_GAP(GAP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .index_i(index),
    .field_ofs_i(ofs), .field_wid_i(wid), .expect_i(expv),
    .done_o(done_o), .matched_o(matched_o), .error_o(error_o),
    .timeout_o(timeout_o), .resp_o(resp_o), .araddr_o(araddr_o),
    .arvalid_o(arvalid_o), .arready_i(arready), .rdata_i(rdata),
    .rresp_i(rresp), .rvalid_i(rvalid), .rready_o(rready_o)
  );

  // subordinate model and bus monitors, all at negedge
  logic [31:0] scr_data [1:8];
  logic [1:0]  scr_resp [1:8];
  int ar_lat = 0, r_lat = 0;
  int sub_st = 0, sub_wait = 0, rd_no = 0;
  logic [31:0] exp_addr = '0;
  bit after_r = 0;
  int gap_run = 0, gap_bad = 0, addr_bad = 0, ar_bad = 0, rr_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      sub_st = 0; sub_wait = 0;
      arready <= 1'b0; rvalid <= 1'b0;
    end else begin
      case (sub_st)
        0: begin
          arready <= 1'b0; rvalid <= 1'b0;
          if (arvalid_o) begin
            if (after_r) begin
              if (gap_run != GAP) gap_bad++;
              after_r = 0;
            end
            if (!rready_o) rr_bad++;
            if (araddr_o !== exp_addr) addr_bad++;
            if (sub_wait >= ar_lat) begin
              arready <= 1'b1; sub_st = 1;
            end else sub_wait++;
          end else if (after_r && !rready_o) gap_run++;
        end
        1: begin
          arready <= 1'b0;
          if (arvalid_o) ar_bad++;
          rd_no++; sub_wait = 0; sub_st = 2;
        end
        2: begin
          if (!rready_o) rr_bad++;
          if (sub_wait >= r_lat) begin
            rvalid <= 1'b1;
            rdata  <= scr_data[(rd_no > 8) ? 8 : rd_no];
            rresp  <= scr_resp[(rd_no > 8) ? 8 : rd_no];
            sub_st = 3;
          end else sub_wait++;
        end
        default: begin
          rvalid <= 1'b0;
          if (rready_o) rr_bad++;
          after_r = 1; gap_run = 1; sub_wait = 0; sub_st = 0;
        end
      endcase
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] place(logic [31:0] v, int o, int w, logic [31:0] noise);
    logic [31:0] m;
    m = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    return ((v & m) << o) | (noise & ~(m << o));
  endfunction

  function automatic logic [31:0] kind_of();
    return {29'd0, timeout_o, error_o, matched_o};
  endfunction

  task automatic run_poll(input vec_t v, input int n, input bit inject);
    bit injected = 0;
    bit seen = 0;
    for (int k = 1; k <= 8; k++) begin
      scr_data[k] = (k == int'(v.match_at)) ?
        place(v.expv, int'(v.ofs), int'(v.wid), 32'h5A5A_C3C3 ^ k) :
        place(v.expv ^ 32'h1, int'(v.ofs), int'(v.wid), 32'hC3C3_5A5A ^ k);
      scr_resp[k] = (k == int'(v.err_at)) ? v.code : 2'b00;
    end
    ar_lat = n % 3; r_lat = (2 * n) % 3;
    @(negedge clk);
    index = v.idx; ofs = v.ofs; wid = v.wid; expv = v.expv;
    exp_addr = (BASE + 32'(v.idx)) << 2;
    rd_no = 0; after_r = 0; gap_bad = 0; addr_bad = 0; ar_bad = 0; rr_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 status cleared by start", kind_of(), 0);
    chk("R2 arvalid and rready raised after start", {30'd0, arvalid_o, rready_o}, 3);
    for (int c = 0; c < 400 && !seen; c++) begin
      if (done_o) seen = 1;
      else begin
        if (inject && !injected && rd_no == 1 && !arvalid_o && !rready_o) begin
          index = 12'h008; start = 1'b1; injected = 1;
        end else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
    chk("R8 done pulse seen", {31'd0, seen}, 1);
    chk(v.kind == 3'd1 ? "R4 outcome" : v.kind == 3'd2 ? "R5 outcome" : "R7 outcome",
        kind_of(), {29'd0, v.kind});
    chk(v.kind == 3'd2 ? "R5 response code" : "R4 response code", {30'd0, resp_o}, {30'd0, v.resp});
    chk(inject ? "R9 read count" : "R7 read count", rd_no, {28'd0, v.reads});
    chk(inject ? "R9 address kept" : "R2 read address", addr_bad, 0);
    chk("R2 arvalid dropped after handshake", ar_bad, 0);
    chk("R3 rready held then dropped", rr_bad, 0);
    chk("R6 idle gap length", gap_bad, 0);
    @(negedge clk);
    chk("R8 done is one cycle", {31'd0, done_o}, 0);
    @(negedge clk);
    chk("R8 status held", kind_of(), {29'd0, v.kind});
    chk("R7 no read after done", {30'd0, arvalid_o, rready_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {24'd0, arvalid_o, rready_o, done_o, matched_o,
        error_o, timeout_o, resp_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 8; i++) run_poll(VECS[i], i, 1'b0);

    // R9: start pulse with another index during the idle gap of a timeout poll
    run_poll('{12'h004, 5'd0, 6'd8, 32'h0000_0011, 4'd0, 4'd0, 2'd0,
               3'd4, 4'd3, 2'd0}, 1, 1'b1);

    // R1: reset in the middle of a read
    for (int k = 1; k <= 8; k++) begin scr_data[k] = '0; scr_resp[k] = 2'b00; end
    ar_lat = 6;
    @(negedge clk);
    index = 12'h010; wid = 6'd8; expv = 32'hFF; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset mid-poll", {24'd0, arvalid_o, rready_o, done_o, matched_o,
        error_o, timeout_o, resp_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after reset release", {30'd0, arvalid_o, rready_o}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL R8 watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule